// File: doc/BRIEF.md
# Crossbar Hebbian Programming-Pulse Driver

This block runs in the weight-update phase of one layer of an M×N single-synapse crossbar. On an update-start strobe it captures the binary presynaptic vector (one bit per row) and the winner vector (one bit per column, normally one-hot). For a fixed number of clock cycles it then drives every word line and every bit line either to the high level or to ground. Outside that window every line sits at its idle level and no programming drive is present.

The update rule runs the opposite way to plain coincidence learning. A row that is active while its column did not win raises the weight. A row that is silent while its column won lowers it. A cell whose row and column are both active, or both silent, keeps its weight. In the crossbar this comes out of the line levels directly. A raised cell sees its word line high and its bit line at ground. A lowered cell sees the reverse. Cells whose two lines sit at the same level see no programming voltage.

A saturating digital model of every cell weight is included. It moves by one code at the end of each pulse and gives the layer a readable image of the array state.

Top module: `hebb_update_driver`

## Requirements
- R1: After reset, `pulse_active`, every `wl_drive_hi` bit and every `bl_drive_hi` bit are 0, and every cell weight equals `INIT_W`.
- R2: A strobe on `upd_start` sampled while idle makes `pulse_active` go to 1 after that edge. It stays at 1 for exactly `PULSE_CYC` cycles and then returns to 0.
- R3: While the pulse runs, `wl_drive_hi[i]` is 1 (word line high) exactly when row i was active at the strobe. `bl_drive_hi[j]` is 1 (bit line high) exactly when column j was a winner at the strobe. A 0 during the pulse means the line is driven to ground.
- R4: Whenever `pulse_active` is 0, all drive bits are 0.
- R5: The weight of cell (row i, column j) is read at bits `[(i*COLS+j)*WBITS +: WBITS]` of `weight_flat`. When row i is active and column j is not a winner, that weight rises by one code at the edge where the pulse ends.
- R6: When row i is silent and column j is a winner, the cell weight falls by one code at the end of the pulse.
- R7: When row i and column j are both active, or both inactive, the cell weight is unchanged.
- R8: Weights saturate. A raise at code 2^WBITS−1 and a lower at code 0 leave the weight where it is.
- R9: A strobe arriving while a pulse runs is ignored. Changes on the row and column inputs during a pulse alter neither the drives nor the update.
- R10: Weights change only at the edge that ends a pulse, and by at most one code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| upd_start | input | 1 | Update-phase start strobe |
| pre_spk | input | ROWS | Row (presynaptic) activity vector |
| post_win | input | COLS | Column winner vector |
| wl_drive_hi | output | ROWS | Per word line: 1 = high, 0 = ground (during pulse) |
| bl_drive_hi | output | COLS | Per bit line: 1 = high, 0 = ground (during pulse) |
| pulse_active | output | 1 | High for the whole programming pulse |
| weight_flat | output | ROWS*COLS*WBITS | Packed digital weight model |

## Verification
The strobe is sampled at one edge. `pulse_active` and the line drives are due in the cycle that follows it, with one register on the path. They hold through `PULSE_CYC` cycles. The weights and the return to idle are due together at the edge that closes the pulse, `PULSE_CYC` edges after the strobe edge. The bench drives inputs on falling edges and samples on falling edges. It counts edges from the strobe, so each result is compared in the exact half-cycle the requirements place it in. Inside each pulse it also checks that nothing changes early: mid-pulse strobes and scrambled inputs must leave every observed output as it was.

// File: rtl/hebb_upd_pkg.sv
package hebb_upd_pkg;

    typedef enum logic [1:0] {
        ACT_HOLD  = 2'b00,
        ACT_RAISE = 2'b01,
        ACT_LOWER = 2'b10
    } cell_act_e;

    // Anti-coincidence rule: active row with losing column raises,
    // silent row with winning column lowers, anything else holds.
    function automatic cell_act_e cell_action(input logic pre, input logic post);
        cell_act_e act;
        unique case ({pre, post})
            2'b10:   act = ACT_RAISE;
            2'b01:   act = ACT_LOWER;
            default: act = ACT_HOLD;
        endcase
        return act;
    endfunction

    // Pulse length in cycles, rounded up, from a duration and a clock period in ns.
    function automatic int cycles_for(input int pulse_ns, input int clk_ns);
        return (pulse_ns + clk_ns - 1) / clk_ns;
    endfunction

endpackage

// File: rtl/hebb_pulse_timer.sv
module hebb_pulse_timer #(
    parameter int PULSE_CYC = 15
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    output logic accept,
    output logic busy,
    output logic last
);
    localparam int CNT_W = $clog2(PULSE_CYC + 1);
    localparam logic [CNT_W-1:0] LOAD_V = CNT_W'(PULSE_CYC);

    logic [CNT_W-1:0] remain_q;

    assign busy   = (remain_q != '0);
    assign accept = start && !busy;
    assign last   = (remain_q == CNT_W'(1));

    always_ff @(posedge clk) begin
        if (rst) begin
            remain_q <= '0;
        end else if (accept) begin
            remain_q <= LOAD_V;
        end else if (busy) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end
endmodule

// File: rtl/hebb_line_drive.sv
module hebb_line_drive #(
    parameter int ROWS = 9,
    parameter int COLS = 3
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            accept,
    input  logic            busy,
    input  logic [ROWS-1:0] pre_in,
    input  logic [COLS-1:0] post_in,
    output logic [ROWS-1:0] pre_q,
    output logic [COLS-1:0] post_q,
    output logic [ROWS-1:0] wl_hi,
    output logic [COLS-1:0] bl_hi
);
    always_ff @(posedge clk) begin
        if (rst) begin
            pre_q  <= '0;
            post_q <= '0;
        end else if (accept) begin
            pre_q  <= pre_in;
            post_q <= post_in;
        end
    end

    // Row high for active rows, column high for winners; idle means all low.
    for (genvar r = 0; r < ROWS; r++) begin : g_wl
        assign wl_hi[r] = busy & pre_q[r];
    end
    for (genvar c = 0; c < COLS; c++) begin : g_bl
        assign bl_hi[c] = busy & post_q[c];
    end
endmodule

// File: rtl/hebb_weight_array.sv
module hebb_weight_array
    import hebb_upd_pkg::*;
#(
    parameter int ROWS   = 9,
    parameter int COLS   = 3,
    parameter int WBITS  = 4,
    parameter int INIT_W = 8
) (
    input  logic                        clk,
    input  logic                        rst,
    input  logic                        commit,
    input  logic [ROWS-1:0]             pre_q,
    input  logic [COLS-1:0]             post_q,
    output logic [ROWS*COLS*WBITS-1:0]  weight_flat
);
    localparam logic [WBITS-1:0] WMAX  = '1;
    localparam logic [WBITS-1:0] WINIT = WBITS'(INIT_W);

    for (genvar r = 0; r < ROWS; r++) begin : g_row
        for (genvar c = 0; c < COLS; c++) begin : g_col
            logic [WBITS-1:0] w_q;
            cell_act_e        act;

            assign act = cell_action(pre_q[r], post_q[c]);

            always_ff @(posedge clk) begin
                if (rst) begin
                    w_q <= WINIT;
                end else if (commit) begin
                    unique case (act)
                        ACT_RAISE: if (w_q != WMAX) w_q <= w_q + WBITS'(1);
                        ACT_LOWER: if (w_q != '0)   w_q <= w_q - WBITS'(1);
                        default:   w_q <= w_q;
                    endcase
                end
            end

            assign weight_flat[(r*COLS+c)*WBITS +: WBITS] = w_q;
        end
    end
endmodule

// File: rtl/hebb_update_driver.sv
module hebb_update_driver
    import hebb_upd_pkg::*;
#(
    parameter int ROWS      = 9,
    parameter int COLS      = 3,
    parameter int WBITS     = 4,
    parameter int INIT_W    = 8,
    parameter int PULSE_CYC = cycles_for(150, 10)
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       upd_start,
    input  logic [ROWS-1:0]            pre_spk,
    input  logic [COLS-1:0]            post_win,
    output logic [ROWS-1:0]            wl_drive_hi,
    output logic [COLS-1:0]            bl_drive_hi,
    output logic                       pulse_active,
    output logic [ROWS*COLS*WBITS-1:0] weight_flat
);
    logic            accept, busy, last;
    logic [ROWS-1:0] pre_q;
    logic [COLS-1:0] post_q;

    hebb_pulse_timer #(.PULSE_CYC(PULSE_CYC)) u_timer (
        .clk    (clk),
        .rst    (rst),
        .start  (upd_start),
        .accept (accept),
        .busy   (busy),
        .last   (last)
    );

    hebb_line_drive #(.ROWS(ROWS), .COLS(COLS)) u_lines (
        .clk     (clk),
        .rst     (rst),
        .accept  (accept),
        .busy    (busy),
        .pre_in  (pre_spk),
        .post_in (post_win),
        .pre_q   (pre_q),
        .post_q  (post_q),
        .wl_hi   (wl_drive_hi),
        .bl_hi   (bl_drive_hi)
    );

    hebb_weight_array #(
        .ROWS(ROWS), .COLS(COLS), .WBITS(WBITS), .INIT_W(INIT_W)
    ) u_weights (
        .clk         (clk),
        .rst         (rst),
        .commit      (last),
        .pre_q       (pre_q),
        .post_q      (post_q),
        .weight_flat (weight_flat)
    );

    assign pulse_active = busy;
endmodule

// File: rtl/hebb_update_driver_chk.sv
module hebb_update_driver_chk #(
    parameter int ROWS      = 9,
    parameter int COLS      = 3,
    parameter int WBITS     = 4,
    parameter int PULSE_CYC = 15
) (
    input logic                       clk,
    input logic                       rst,
    input logic                       upd_start,
    input logic [ROWS-1:0]            wl_drive_hi,
    input logic [COLS-1:0]            bl_drive_hi,
    input logic                       pulse_active,
    input logic [ROWS*COLS*WBITS-1:0] weight_flat
);
    int run_len;

    always_ff @(posedge clk) begin
        if (rst)               run_len <= 0;
        else if (pulse_active) run_len <= run_len + 1;
        else                   run_len <= 0;
    end

    // R4
    idle_lines_low_chk: assert property (@(posedge clk) disable iff (rst)
        !pulse_active |-> (wl_drive_hi == '0 && bl_drive_hi == '0));

    // R2
    start_accept_chk: assert property (@(posedge clk) disable iff (rst)
        (upd_start && !pulse_active) |=> pulse_active);

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (rst)
        $fell(pulse_active) |-> (run_len == PULSE_CYC));

    // R2
    pulse_no_overrun_chk: assert property (@(posedge clk) disable iff (rst)
        run_len <= PULSE_CYC);

    // R9
    drive_steady_chk: assert property (@(posedge clk) disable iff (rst)
        (pulse_active && $past(pulse_active)) |-> ($stable(wl_drive_hi) && $stable(bl_drive_hi)));

    // R10
    weight_commit_edge_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(weight_flat) |-> $fell(pulse_active));

    for (genvar g = 0; g < ROWS*COLS; g++) begin : g_cell
        // R10
        step_one_chk: assert property (@(posedge clk) disable iff (rst)
            !$stable(weight_flat[g*WBITS +: WBITS]) |->
                ((weight_flat[g*WBITS +: WBITS] == $past(weight_flat[g*WBITS +: WBITS]) + WBITS'(1)) ||
                 (weight_flat[g*WBITS +: WBITS] == $past(weight_flat[g*WBITS +: WBITS]) - WBITS'(1))));
    end
endmodule

bind hebb_update_driver hebb_update_driver_chk #(
    .ROWS(ROWS), .COLS(COLS), .WBITS(WBITS), .PULSE_CYC(PULSE_CYC)
) u_chk (
    .clk          (clk),
    .rst          (rst),
    .upd_start    (upd_start),
    .wl_drive_hi  (wl_drive_hi),
    .bl_drive_hi  (bl_drive_hi),
    .pulse_active (pulse_active),
    .weight_flat  (weight_flat)
);

// File: tb/hebb_update_driver_bench.sv
module hebb_update_driver_bench;
    localparam int ROWS   = 9;
    localparam int COLS   = 3;
    localparam int WBITS  = 3;
    localparam int INIT_W = 4;
    localparam int PULSE  = hebb_upd_pkg::cycles_for(150, 8);
    localparam int WMAX   = (1 << WBITS) - 1;

    logic                       clk = 1'b0;
    logic                       rst = 1'b1;
    logic                       upd_start = 1'b0;
    logic [ROWS-1:0]            pre_spk = '0;
    logic [COLS-1:0]            post_win = '0;
    logic [ROWS-1:0]            wl_drive_hi;
    logic [COLS-1:0]            bl_drive_hi;
    logic                       pulse_active;
    logic [ROWS*COLS*WBITS-1:0] weight_flat;

    int n_cmp = 0;
    int n_bad = 0;
    int exp_w [ROWS][COLS];

    always #4 clk = ~clk;

    hebb_update_driver #(
        .ROWS(ROWS), .COLS(COLS), .WBITS(WBITS), .INIT_W(INIT_W), .PULSE_CYC(PULSE)
    ) u_hebb_update_driver (
        .clk(clk), .rst(rst), .upd_start(upd_start), .pre_spk(pre_spk), .post_win(post_win),
        .wl_drive_hi(wl_drive_hi), .bl_drive_hi(bl_drive_hi),
        .pulse_active(pulse_active), .weight_flat(weight_flat)
    );

    task automatic check(input string req, input longint act, input longint exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic check_weights(input string req);
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++)
                check(req, longint'(weight_flat[(i*COLS+j)*WBITS +: WBITS]), longint'(exp_w[i][j]));
    endtask

    // R5 R6 R7 R8 model of one pulse worth of updates
    task automatic model_update(input logic [ROWS-1:0] pv, input logic [COLS-1:0] wv);
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) begin
                if (pv[i] && !wv[j] && exp_w[i][j] < WMAX) exp_w[i][j]++;
                else if (!pv[i] && wv[j] && exp_w[i][j] > 0) exp_w[i][j]--;
            end
    endtask

    // One update phase; mid-pulse strobe and input scrambling test R9.
    task automatic run_update(input string tag, input logic [ROWS-1:0] pv, input logic [COLS-1:0] wv);
        @(negedge clk);
        pre_spk   = pv;
        post_win  = wv;
        upd_start = 1'b1;
        for (int k = 1; k <= PULSE; k++) begin
            @(negedge clk);
            check({tag, " R2 pulse_active"}, longint'(pulse_active), 1);
            check({tag, " R3 word lines"}, longint'(wl_drive_hi), longint'(pv));
            check({tag, " R3 bit lines"}, longint'(bl_drive_hi), longint'(wv));
            if (k < PULSE) check_weights({tag, " R10 no early change"});
            upd_start = (k == PULSE / 2);
            pre_spk   = ~pv;
            post_win  = ~wv;
        end
        upd_start = 1'b0;
        model_update(pv, wv);
        @(negedge clk);
        check({tag, " R2 pulse end"}, longint'(pulse_active), 0);
        check({tag, " R4 idle word lines"}, longint'(wl_drive_hi), 0);
        check({tag, " R4 idle bit lines"}, longint'(bl_drive_hi), 0);
        check_weights({tag, " R5/R6/R7 weights"});
        pre_spk  = '0;
        post_win = '0;
        @(negedge clk);
        check({tag, " R9 no restart"}, longint'(pulse_active), 0);
    endtask

    task automatic scen_reset();
        for (int i = 0; i < ROWS; i++)
            for (int j = 0; j < COLS; j++) exp_w[i][j] = INIT_W;
        check("R1 pulse_active", longint'(pulse_active), 0);
        check("R1 word lines", longint'(wl_drive_hi), 0);
        check("R1 bit lines", longint'(bl_drive_hi), 0);
        check_weights("R1 init weights");
    endtask

    task automatic scen_idle_inputs();
        // R4: inputs toggling without strobe leave every line low
        @(negedge clk);
        pre_spk  = '1;
        post_win = '1;
        repeat (3) begin
            @(negedge clk);
            check("R4 no strobe lines", longint'({wl_drive_hi, bl_drive_hi}), 0);
            check("R4 no strobe active", longint'(pulse_active), 0);
        end
        check_weights("R4 no strobe weights");
        pre_spk  = '0;
        post_win = '0;
    endtask

    task automatic scen_mixed();
        run_update("R5 R6 mixed A", 9'b101010101, 3'b010);
        run_update("R5 R6 mixed B", 9'b000011110, 3'b001);
    endtask

    task automatic scen_coincidence();
        run_update("R7 both active", '1, '1);
        run_update("R7 both silent", '0, '0);
    endtask

    task automatic scen_saturate();
        for (int n = 0; n < WMAX + 1; n++) run_update("R8 raise to max", '1, '0);
        for (int n = 0; n < WMAX + 2; n++) run_update("R8 lower to zero", '0, '1);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL R2 watchdog expired: actual hung expected done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        scen_reset();
        scen_idle_inputs();
        scen_mixed();
        scen_coincidence();
        scen_saturate();
        run_update("R3 single winner", 9'b110000011, 3'b100);
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule